// File: doc/BRIEF.md
# Paired-Operand Thread Execution Pipeline

This block runs threads whose inputs already sit in a register context. It is a four-stage in-order pipeline: fetch, decode with register read, execute, and write-back. A thread is handed in as a context number and a start address. Fetch then steps a program counter through instruction memory, one word per cycle, until it meets a stop instruction. Every instruction names one register pair. The even register of the pair is the left operand and the odd register is the right operand. An instruction may write up to two destination registers in the same write-back cycle.

The pipeline has no data-memory path and never stalls. Registers are written once per thread, so there is no hazard logic for write-after-read or write-after-write. A read-after-write between neighbouring instructions is served by forwarding from the execute and write-back stages into decode. The register file is addressed by context number and register number. Write-back activity and thread completion are driven out on ports.

Top module: `rp_exec_pipe`

## Requirements
- R1: During reset and in the first cycle after it, `threadAccept` is 1, both write-back valids are 0 and `doneValid` is 0.
- R2: An instruction word is opcode in [15:12], pair field in [11:8], destination A in [7:4] and destination B in [3:0]. Bit 8 is ignored: the left operand comes from the even register and the right from the odd register. Register 0 always reads as zero, and a destination of 0 is never written.
- R3: Single-result opcodes are 1 add, 2 subtract (left minus right), 3 and, 4 or, 5 xor, and 9 shift left (left shifted by the low 4 bits of right). Each writes its result to both destination A and destination B. All arithmetic wraps at 16 bits.
- R4: Opcode 6 writes left+right to A and left−right to B. Opcode 7 writes right to A and left to B. Both results appear on the two write-back ports in the same cycle.
- R5: Opcode 8 writes the zero-extended 8-bit value {bits[11:8], bits[3:0]} to destination A only.
- R6: If a thread is accepted at clock edge A, the instruction at offset j reaches the write-back ports in the cycle after edge A+3+j. Exactly one instruction advances per cycle, and `imemAddr` steps by one while a thread is running.
- R7: An instruction sees the results of the two instructions immediately before it in the same context, with no stall.
- R8: Each context has its own registers. A write in one context never changes what another context reads. `wbCtx` gives the context of the instruction in write-back.
- R9: Opcode 15 (stop) writes nothing. It raises `doneValid` for one cycle with `doneCtx` in its write-back cycle. If it sits at offset s, the next waiting thread is accepted at edge A+s+2, and `threadAccept` falls right after an acceptance.
- R10: Opcodes 0 and 10 through 14 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| threadValid | input | 1 | A ready thread is offered |
| threadCtx | input | 2 | Context number of the offered thread |
| threadPc | input | 8 | Start address of the offered thread |
| threadAccept | output | 1 | Fetch is idle and takes the offered thread |
| imemAddr | output | 8 | Instruction memory address |
| imemData | input | 16 | Instruction word at imemAddr (same-cycle read) |
| wbValidA | output | 1 | Destination A is being written |
| wbRegA | output | 4 | Destination A register number |
| wbDataA | output | 16 | Destination A value |
| wbValidB | output | 1 | Destination B is being written |
| wbRegB | output | 4 | Destination B register number |
| wbDataB | output | 16 | Destination B value |
| wbCtx | output | 2 | Context of the instruction in write-back |
| doneValid | output | 1 | A thread retires this cycle |
| doneCtx | output | 2 | Context of the retiring thread |

## Verification
The hardest situation to reach is two threads in flight at once. The previous thread's last results are still in execute and write-back while the next thread is already in fetch and decode. Forwarding must then match on the context as well as the register number. The stimulus keeps the next dispatch request waiting, so the handover happens at the earliest possible edge. Contexts are reused and register numbers overlap across threads. A cycle-accurate behavioural model predicts every write-back and retire, dependent chains test back-to-back forwarding, and a long generated program mixes every opcode.

// File: rtl/rp_pipe_pkg.sv
package rp_pipe_pkg;
  localparam logic [3:0] OP_NOP    = 4'd0;
  localparam logic [3:0] OP_ADD    = 4'd1;
  localparam logic [3:0] OP_SUB    = 4'd2;
  localparam logic [3:0] OP_AND    = 4'd3;
  localparam logic [3:0] OP_OR     = 4'd4;
  localparam logic [3:0] OP_XOR    = 4'd5;
  localparam logic [3:0] OP_ADDSUB = 4'd6;
  localparam logic [3:0] OP_SWAP   = 4'd7;
  localparam logic [3:0] OP_PUTI   = 4'd8;
  localparam logic [3:0] OP_SHL    = 4'd9;
  localparam logic [3:0] OP_STOP   = 4'd15;

  // strobes from fetch control to the datapath
  typedef struct packed {
    logic issue;   // an instruction word is valid on imemData this cycle
    logic isStop;  // that word retires the thread
  } fetchStrobe_t;
endpackage

// File: rtl/rp_fetch_ctrl.sv
module rp_fetch_ctrl
  import rp_pipe_pkg::*;
#(
  parameter int CTX_W = 2,
  parameter int PC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  threadValid,
  input  logic [CTX_W-1:0]      threadCtx,
  input  logic [PC_W-1:0]       threadPc,
  input  logic [3:0]            imemOp,
  output logic                  threadAccept,
  output logic [PC_W-1:0]       imemAddr,
  output logic [CTX_W-1:0]      issueCtx,
  output fetchStrobe_t          strobe
);
  logic             active;
  logic [PC_W-1:0]  pc;
  logic [CTX_W-1:0] ctx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      pc     <= '0;
      ctx    <= '0;
    end else if (!active) begin
      if (threadValid) begin
        active <= 1'b1;
        pc     <= threadPc;
        ctx    <= threadCtx;
      end
    end else begin
      pc <= pc + 1'b1;
      if (imemOp == OP_STOP) active <= 1'b0;
    end
  end

  assign threadAccept  = !active;
  assign imemAddr      = pc;
  assign issueCtx      = ctx;
  assign strobe.issue  = active;
  assign strobe.isStop = active && (imemOp == OP_STOP);
endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import rp_pipe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTX_W  = 2,
  parameter int REG_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fetchStrobe_t            strobe,
  input  logic [CTX_W-1:0]        issueCtx,
  input  logic [4+3*REG_W-1:0]    imemData,
  output logic                    wbValidA,
  output logic [REG_W-1:0]        wbRegA,
  output logic [DATA_W-1:0]       wbDataA,
  output logic                    wbValidB,
  output logic [REG_W-1:0]        wbRegB,
  output logic [DATA_W-1:0]       wbDataB,
  output logic [CTX_W-1:0]        wbCtx,
  output logic                    doneValid,
  output logic [CTX_W-1:0]        doneCtx
);
  localparam int INSTR_W  = 4 + 3*REG_W;
  localparam int RF_DEPTH = (1 << CTX_W) * (1 << REG_W);
  localparam int SHW      = $clog2(DATA_W);

  logic [DATA_W-1:0] rf [RF_DEPTH];

  // fetch -> decode
  logic               fdValid, fdStop;
  logic [CTX_W-1:0]   fdCtx;
  logic [INSTR_W-1:0] fdInstr;
  // decode -> execute
  logic               deValid, deStop;
  logic [CTX_W-1:0]   deCtx;
  logic [3:0]         deOp;
  logic [REG_W-1:0]   deA, deB;
  logic [DATA_W-1:0]  deL, deR, deImm;
  // execute -> write-back
  logic               ewStop, ewWrA, ewWrB;
  logic [CTX_W-1:0]   ewCtx;
  logic [REG_W-1:0]   ewRegA, ewRegB;
  logic [DATA_W-1:0]  ewDataA, ewDataB;

  logic [REG_W-1:0]   pairField;
  logic [REG_W-1:0]   srcReg [2];
  logic [DATA_W-1:0]  opnd   [2];
  logic               exWrA, exWrB;
  logic [DATA_W-1:0]  exResA, exResB;

  assign pairField = fdInstr[INSTR_W-5 -: REG_W];

  // two operand read ports with forwarding, newest producer first
  for (genvar s = 0; s < 2; s++) begin : g_read
    assign srcReg[s] = {pairField[REG_W-1:1], s[0]};
    always_comb begin
      if (srcReg[s] == '0)                                   opnd[s] = '0;
      else if (exWrB && deCtx == fdCtx && deB == srcReg[s])  opnd[s] = exResB;
      else if (exWrA && deCtx == fdCtx && deA == srcReg[s])  opnd[s] = exResA;
      else if (ewWrB && ewCtx == fdCtx && ewRegB == srcReg[s]) opnd[s] = ewDataB;
      else if (ewWrA && ewCtx == fdCtx && ewRegA == srcReg[s]) opnd[s] = ewDataA;
      else opnd[s] = rf[{fdCtx, srcReg[s]}];
    end
  end

  // execute
  always_comb begin
    exResA = '0;
    exResB = '0;
    exWrA  = 1'b0;
    exWrB  = 1'b0;
    case (deOp)
      OP_ADD:    begin exResA = deL + deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_SUB:    begin exResA = deL - deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_AND:    begin exResA = deL & deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_OR:     begin exResA = deL | deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_XOR:    begin exResA = deL ^ deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_SHL:    begin exResA = deL << deR[SHW-1:0]; exWrA = 1'b1; exWrB = 1'b1; end
      OP_ADDSUB: begin exResA = deL + deR;  exWrA = 1'b1; exWrB = 1'b1; end
      OP_SWAP:   begin exResA = deR;        exWrA = 1'b1; exWrB = 1'b1; end
      OP_PUTI:   begin exResA = deImm;      exWrA = 1'b1; end
      default:   ;
    endcase
    if (deOp == OP_ADDSUB)    exResB = deL - deR;
    else if (deOp == OP_SWAP) exResB = deL;
    else                      exResB = exResA;
    exWrA = exWrA && deValid && (deA != '0);
    exWrB = exWrB && deValid && (deB != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fdValid <= 1'b0; fdStop <= 1'b0; fdCtx <= '0; fdInstr <= '0;
      deValid <= 1'b0; deStop <= 1'b0; deCtx <= '0; deOp <= '0;
      deA <= '0; deB <= '0; deL <= '0; deR <= '0; deImm <= '0;
      ewStop <= 1'b0; ewWrA <= 1'b0; ewWrB <= 1'b0; ewCtx <= '0;
      ewRegA <= '0; ewRegB <= '0; ewDataA <= '0; ewDataB <= '0;
      for (int i = 0; i < RF_DEPTH; i++) rf[i] <= '0;
    end else begin
      fdValid <= strobe.issue;
      fdStop  <= strobe.isStop;
      fdCtx   <= issueCtx;
      fdInstr <= imemData;

      deValid <= fdValid && !fdStop;
      deStop  <= fdValid && fdStop;
      deCtx   <= fdCtx;
      deOp    <= fdInstr[INSTR_W-1 -: 4];
      deA     <= fdInstr[2*REG_W-1 -: REG_W];
      deB     <= fdInstr[REG_W-1:0];
      deL     <= opnd[0];
      deR     <= opnd[1];
      deImm   <= DATA_W'({pairField, fdInstr[REG_W-1:0]});

      ewStop  <= deStop;
      ewWrA   <= exWrA;
      ewWrB   <= exWrB;
      ewCtx   <= deCtx;
      ewRegA  <= deA;
      ewRegB  <= deB;
      ewDataA <= exResA;
      ewDataB <= exResB;

      // port B is written last so it wins a same-register clash
      if (ewWrA) rf[{ewCtx, ewRegA}] <= ewDataA;
      if (ewWrB) rf[{ewCtx, ewRegB}] <= ewDataB;
    end
  end

  assign wbValidA  = ewWrA;
  assign wbRegA    = ewRegA;
  assign wbDataA   = ewDataA;
  assign wbValidB  = ewWrB;
  assign wbRegB    = ewRegB;
  assign wbDataB   = ewDataB;
  assign wbCtx     = ewCtx;
  assign doneValid = ewStop;
  assign doneCtx   = ewCtx;
endmodule

// File: rtl/rp_exec_pipe.sv
module rp_exec_pipe
  import rp_pipe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CTX_COUNT = 4,
  parameter int REG_W     = 4,
  parameter int PC_W      = 8,
  localparam int CTX_W    = $clog2(CTX_COUNT),
  localparam int INSTR_W  = 4 + 3*REG_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               threadValid,
  input  logic [CTX_W-1:0]   threadCtx,
  input  logic [PC_W-1:0]    threadPc,
  output logic               threadAccept,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic               wbValidA,
  output logic [REG_W-1:0]   wbRegA,
  output logic [DATA_W-1:0]  wbDataA,
  output logic               wbValidB,
  output logic [REG_W-1:0]   wbRegB,
  output logic [DATA_W-1:0]  wbDataB,
  output logic [CTX_W-1:0]   wbCtx,
  output logic               doneValid,
  output logic [CTX_W-1:0]   doneCtx
);
  fetchStrobe_t     strobe;
  logic [CTX_W-1:0] issueCtx;

  rp_fetch_ctrl #(.CTX_W(CTX_W), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .threadValid(threadValid), .threadCtx(threadCtx), .threadPc(threadPc),
    .imemOp(imemData[INSTR_W-1 -: 4]),
    .threadAccept(threadAccept), .imemAddr(imemAddr),
    .issueCtx(issueCtx), .strobe(strobe)
  );

  rp_datapath #(.DATA_W(DATA_W), .CTX_W(CTX_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueCtx(issueCtx),
    .imemData(imemData),
    .wbValidA(wbValidA), .wbRegA(wbRegA), .wbDataA(wbDataA),
    .wbValidB(wbValidB), .wbRegB(wbRegB), .wbDataB(wbDataB),
    .wbCtx(wbCtx), .doneValid(doneValid), .doneCtx(doneCtx)
  );
endmodule

// File: rtl/rp_pipe_checker.sv
module rp_pipe_checker #(
  parameter int PC_W  = 8,
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             threadValid,
  input logic             threadAccept,
  input logic [PC_W-1:0]  imemAddr,
  input logic             wbValidA,
  input logic [REG_W-1:0] wbRegA,
  input logic             wbValidB,
  input logic [REG_W-1:0] wbRegB,
  input logic             doneValid
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> threadAccept && !wbValidA && !wbValidB && !doneValid);

  assert_no_zero_dst_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    wbValidA |-> wbRegA != '0);

  assert_no_zero_dst_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    wbValidB |-> wbRegB != '0);

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !threadAccept |=> threadAccept || (imemAddr == PC_W'($past(imemAddr) + 1)));

  assert_take_once_R9: assert property (@(posedge clk) disable iff (!rstN)
    threadValid && threadAccept |=> !threadAccept);

  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !wbValidA && !wbValidB);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
endmodule

bind rp_exec_pipe rp_pipe_checker #(.PC_W(PC_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .threadValid(threadValid), .threadAccept(threadAccept),
  .imemAddr(imemAddr), .wbValidA(wbValidA), .wbRegA(wbRegA),
  .wbValidB(wbValidB), .wbRegB(wbRegB), .doneValid(doneValid)
);

// File: tb/rp_exec_pipe_tb.sv
module rp_exec_pipe_tb;
  localparam int EXPN = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        threadValid = 1'b0;
  logic [1:0]  threadCtx = '0;
  logic [7:0]  threadPc = '0;
  logic        threadAccept;
  logic [7:0]  imemAddr;
  logic [15:0] imemData;
  logic        wbValidA, wbValidB, doneValid;
  logic [3:0]  wbRegA, wbRegB;
  logic [15:0] wbDataA, wbDataB;
  logic [1:0]  wbCtx, doneCtx;

  always #5 clk = ~clk;

  logic [15:0] imem [256];
  assign imemData = imem[imemAddr];

  rp_exec_pipe u_dut (
    .clk(clk), .rstN(rstN), .threadValid(threadValid), .threadCtx(threadCtx),
    .threadPc(threadPc), .threadAccept(threadAccept), .imemAddr(imemAddr),
    .imemData(imemData), .wbValidA(wbValidA), .wbRegA(wbRegA), .wbDataA(wbDataA),
    .wbValidB(wbValidB), .wbRegB(wbRegB), .wbDataB(wbDataB), .wbCtx(wbCtx),
    .doneValid(doneValid), .doneCtx(doneCtx)
  );

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit finished = 0;
  int unsigned cyc;

  // behavioural reference state
  logic [15:0] mrf [4][16];
  bit          expWa [EXPN], expWb [EXPN], expDone [EXPN];
  logic [3:0]  expRa [EXPN], expRb [EXPN];
  logic [15:0] expDa [EXPN], expDb [EXPN];
  logic [1:0]  expCtx [EXPN];
  bit          obsW [4][16];
  logic [15:0] obsD [4][16];

  always @(posedge clk) if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [3:0] op, input int pair,
                                      input int a, input int b);
    return {op, pair[3:0], a[3:0], b[3:0]};
  endfunction

  function automatic logic [15:0] puti(input int dst, input int imm);
    return {4'd8, imm[7:4], dst[3:0], imm[3:0]};
  endfunction

  // one instruction in program order against the model registers
  task automatic modelStep(input int ctx, input logic [15:0] w, input int idx);
    logic [3:0]  op;
    int          ev, a, b;
    logic [15:0] l, r, ra, rb;
    bit          wa, wb;
    op = w[15:12]; ev = w[11:8] & 14; a = w[7:4]; b = w[3:0];
    l = (ev == 0) ? 16'h0 : mrf[ctx][ev];
    r = mrf[ctx][ev + 1];
    wa = 1; wb = 1; ra = 0;
    case (op)
      4'd1: ra = l + r;
      4'd2: ra = l - r;
      4'd3: ra = l & r;
      4'd4: ra = l | r;
      4'd5: ra = l ^ r;
      4'd9: ra = l << r[3:0];
      4'd6: ra = l + r;
      4'd7: ra = r;
      4'd8: begin ra = {8'h0, w[11:8], w[3:0]}; wb = 0; end
      default: begin wa = 0; wb = 0; end
    endcase
    rb = (op == 4'd6) ? l - r : (op == 4'd7) ? l : ra;
    if (a == 0) wa = 0;
    if (b == 0) wb = 0;
    expCtx[idx] = ctx[1:0];
    if (wa) begin expWa[idx] = 1; expRa[idx] = a[3:0]; expDa[idx] = ra; mrf[ctx][a] = ra; end
    if (wb) begin expWb[idx] = 1; expRb[idx] = b[3:0]; expDb[idx] = rb; mrf[ctx][b] = rb; end
  endtask

  task automatic dispatch(input int ctx, input int pc, output int acc);
    @(negedge clk);
    threadValid = 1; threadCtx = ctx[1:0]; threadPc = pc[7:0];
    while (!threadAccept) @(negedge clk);
    @(posedge clk); #1;
    acc = int'(cyc);
    for (int j = 0; j < 200; j++) begin
      logic [15:0] w;
      int idx;
      w = imem[(pc + j) & 255];
      idx = acc + 3 + j;
      if (w[15:12] == 4'd15) begin
        expDone[idx] = 1; expCtx[idx] = ctx[1:0];
        break;
      end
      modelStep(ctx, w, idx);
    end
    @(negedge clk);
    threadValid = 0;
  endtask

  // cycle compare against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN && running && !finished && cyc < EXPN) begin
      chk(wbValidA == expWa[cyc], "R6", "write-back A valid", wbValidA, expWa[cyc]);
      chk(wbValidB == expWb[cyc], "R6", "write-back B valid", wbValidB, expWb[cyc]);
      chk(doneValid == expDone[cyc], "R9", "done pulse", doneValid, expDone[cyc]);
      if (wbValidA && expWa[cyc]) begin
        chk(wbRegA == expRa[cyc], "R3", "dest A", wbRegA, expRa[cyc]);
        chk(wbDataA == expDa[cyc], "R3", "data A", wbDataA, expDa[cyc]);
      end
      if (wbValidB && expWb[cyc]) begin
        chk(wbRegB == expRb[cyc], "R4", "dest B", wbRegB, expRb[cyc]);
        chk(wbDataB == expDb[cyc], "R4", "data B", wbDataB, expDb[cyc]);
      end
      if (wbValidA || wbValidB || doneValid)
        chk((doneValid ? doneCtx : wbCtx) == expCtx[cyc], "R8", "context tag",
            doneValid ? doneCtx : wbCtx, expCtx[cyc]);
    end
    if (rstN && wbValidA) begin obsW[wbCtx][wbRegA] = 1; obsD[wbCtx][wbRegA] = wbDataA; end
    if (rstN && wbValidB) begin obsW[wbCtx][wbRegB] = 1; obsD[wbCtx][wbRegB] = wbDataB; end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    int a0, a1, a2, a3, a4;
    for (int i = 0; i < 256; i++) imem[i] = 16'hF000;
    for (int c = 0; c < 4; c++) for (int r = 0; r < 16; r++) begin
      mrf[c][r] = 0; obsW[c][r] = 0; obsD[c][r] = 0;
    end
    for (int i = 0; i < EXPN; i++) begin
      expWa[i] = 0; expWb[i] = 0; expDone[i] = 0;
      expRa[i] = 0; expRb[i] = 0; expDa[i] = 0; expDb[i] = 0; expCtx[i] = 0;
    end

    // program at 0: dependent chain in context 1
    imem[0] = puti(2, 8'h35);
    imem[1] = puti(3, 8'h12);
    imem[2] = ins(4'd1, 2, 4, 5);     // r4=r5=0x47, forwarded operands
    imem[3] = ins(4'd6, 2, 6, 7);     // r6=0x47 r7=0x23
    imem[4] = ins(4'd7, 6, 8, 9);     // r8=0x23 r9=0x47
    imem[5] = ins(4'd2, 8, 10, 0);    // r10=0xFFDC, B suppressed
    imem[6] = ins(4'd5, 9, 11, 0);    // odd pair field -> pair 8, r11=0x64
    imem[7] = ins(4'd11, 2, 12, 13);  // undefined opcode
    imem[8] = 16'hF000;
    // program at 32: context 2, same register numbers
    imem[32] = puti(2, 8'h03);
    imem[33] = puti(3, 8'h04);
    imem[34] = ins(4'd9, 2, 4, 0);    // r4=0x30
    imem[35] = puti(1, 8'hF0);
    imem[36] = ins(4'd4, 0, 14, 0);   // r0 reads zero: r14=0xF0
    imem[37] = 16'hF000;
    // program at 64: context 1 reuse, reads earlier results
    imem[64] = ins(4'd1, 2, 12, 13);  // 0x47
    imem[65] = 16'hF000;
    // 96: immediate stop (context 3)
    // 128: generated mix in context 0
    for (int k = 0; k < 40; k++) begin
      int sel;
      logic [3:0] opl [12];
      opl = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd0, 4'd12, 4'd8};
      sel = $urandom_range(0, 11);
      imem[128 + k] = {opl[sel], 12'($urandom_range(0, 4095))};
    end
    imem[168] = 16'hF000;

    // reset state
    repeat (3) @(negedge clk);
    chk(threadAccept == 1, "R1", "accept in reset", threadAccept, 1);
    chk(wbValidA == 0 && wbValidB == 0, "R1", "write-back in reset", wbValidA | wbValidB, 0);
    chk(doneValid == 0, "R1", "done in reset", doneValid, 0);
    rstN = 1;
    @(negedge clk);
    chk(threadAccept == 1 && wbValidA == 0 && doneValid == 0, "R1", "idle after reset",
        {threadAccept, wbValidA, doneValid}, 3'b100);
    running = 1;

    dispatch(1, 0, a0);
    dispatch(2, 32, a1);
    chk(a1 - a0 == 10, "R9", "next accept after stop at 8", a1 - a0, 10);
    repeat (8) @(negedge clk);
    chk(obsD[1][4] == 16'h47 && obsD[1][5] == 16'h47, "R7", "forwarded add", obsD[1][4], 16'h47);
    chk(obsD[1][6] == 16'h47 && obsD[1][7] == 16'h23, "R4", "add/sub pair", obsD[1][7], 16'h23);
    chk(obsD[1][8] == 16'h23 && obsD[1][9] == 16'h47, "R4", "swap", obsD[1][8], 16'h23);
    chk(obsD[1][10] == 16'hFFDC, "R3", "wrapping subtract", obsD[1][10], 16'hFFDC);
    chk(obsD[1][11] == 16'h64, "R2", "odd pair field", obsD[1][11], 16'h64);
    chk(obsW[1][12] == 0 && obsW[1][13] == 0, "R10", "undefined opcode writes", obsW[1][12], 0);
    chk(obsW[1][0] == 0 && obsW[2][0] == 0, "R2", "register 0 never written", obsW[1][0], 0);
    chk(obsD[2][4] == 16'h30, "R3", "shift left", obsD[2][4], 16'h30);
    chk(obsD[2][14] == 16'hF0, "R2", "register 0 reads zero", obsD[2][14], 16'hF0);
    chk(obsD[1][3] == 16'h12 && obsW[1][3], "R5", "immediate load", obsD[1][3], 16'h12);
    chk(obsD[1][4] != obsD[2][4], "R8", "contexts isolated", obsD[2][4], 16'h30);

    dispatch(1, 64, a2);
    dispatch(3, 96, a3);
    chk(a3 - a2 == 3, "R9", "next accept after stop at 1", a3 - a2, 3);
    dispatch(0, 128, a4);
    chk(a4 - a3 == 2, "R9", "next accept after immediate stop", a4 - a3, 2);
    repeat (60) @(negedge clk);
    chk(obsD[1][12] == 16'h47 && obsD[1][13] == 16'h47, "R8", "context reuse reads old values",
        obsD[1][12], 16'h47);
    summary();
  end
endmodule